// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Hardware Table Walk

This block sits between a processor's load/store path and main memory and turns a virtual page number into a physical page number. It keeps a handful of recently used translations in a fully associative array and compares every slot against the lookup key in parallel. That key joins the active context number to the virtual page number. A translation cached under one context can never answer a lookup made under another. A context switch therefore costs two register writes: the context number and the table base. No invalidation is needed.

When no slot matches, the block reads the page-table entry itself. The entry sits in main memory at the table base plus the virtual page number. The block drops its lookup-ready output until the memory answers. A resident entry is cached and returned. A non-resident entry is reported as a page fault, returns no physical page, and is not cached, so a retry after the fault handler runs walks the table again. A one-cycle invalidate input empties the whole array when supervisor software edits a table entry that may be cached.

Top module: `ctx_tlb`

## Requirements
- R1: After reset, `lk_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and no slot holds a translation, so the first lookup misses.
- R2: A lookup accepted at a clock edge (`lk_valid` and `lk_ready` both 1) whose key `{current context, lk_vpn}` matches a cached slot gives `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and the cached `rsp_ppn` and `rsp_dirty` in the very next cycle, with no memory read.
- R3: A lookup that misses raises `mem_req_valid` for exactly one cycle, in the cycle after acceptance, with `mem_req_addr` = table base + the zero-extended `lk_vpn`.
- R4: `lk_ready` is 0 from the cycle after a miss is accepted until the cycle after `mem_rsp_valid` is seen. In that cycle `rsp_valid`=1 and `rsp_hit`=0, and `lk_ready` is 1 again.
- R5: The table word on `mem_rsp_data` is laid out as bit 15 resident, bit 14 dirty, bits 13:0 physical page. A resident word gives `rsp_fault`=0 with its page and dirty bit, and it is cached, so the next lookup of the same page and context hits.
- R6: A non-resident word gives `rsp_fault`=1, `rsp_ppn`=0 and `rsp_dirty`=0, and it is not cached: the next lookup of that page walks the table again.
- R7: A translation cached under one context misses under another context. After switching back, the first context hits without a table read.
- R8: Slots are refilled in round-robin order 0,1,2,3,0,… The refill pointer moves only when an entry is actually cached. With four slots, caching a fifth page evicts the oldest one.
- R9: `inv_all` held for one cycle clears every slot, and every later lookup misses. If `inv_all` coincides with the arrival of a table word, the response is still delivered, but the entry is not cached and the refill pointer does not move.
- R10: Writes to the context register (`ctx_we`) and the table base (`base_we`) take effect for lookups accepted after the write edge, and they leave cached slots untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctx_we | input | 1 | Load the context register |
| ctx_wdata | input | CTX_W | New context number |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | ADDR_W | New table base word address |
| inv_all | input | 1 | Invalidate every cached slot |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_ready | output | 1 | Block can accept a lookup |
| rsp_valid | output | 1 | Translation result present |
| rsp_hit | output | 1 | Result came from the cache |
| rsp_fault | output | 1 | Page not resident |
| rsp_dirty | output | 1 | Dirty bit of the page |
| rsp_ppn | output | PPN_W | Physical page number |
| mem_req_valid | output | 1 | Table read request, one cycle |
| mem_req_addr | output | ADDR_W | Word address of the table entry |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | PPN_W+2 | Table word {resident, dirty, page} |

## Verification
The delicate overlap is a global invalidate landing in the same cycle as a returning table word that is about to be cached. The bench provokes it by raising `inv_all` together with `mem_rsp_valid` during some walks. It judges the outcome by requiring that the response still arrives with the fetched page, that the same page then misses again, and that the refill order seen in later evictions shows the pointer did not move. Random traffic over a small page set and two contexts, with random memory latency, creates the remaining hit, miss, eviction and context-mismatch mixes against a bench model.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_WAIT = 1'b1
  } walk_state_e;

  // next slot in a circular order over n slots
  function automatic int unsigned slot_after(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  import ctx_tlb_pkg::*;

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= IDX_W'(slot_after(int'(ptr_q), ENTRIES));
  end

  assign ptr = ptr_q;

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_q));

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 26,
  parameter int PPN_W   = 14,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_dirty
);

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] dirty_vec;
  logic [PPN_W-1:0]   ppn_arr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             v_q;
    logic             d_q;
    logic [TAG_W-1:0] t_q;
    logic [PPN_W-1:0] p_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else if (inv_all) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
        d_q <= wr_dirty;
        t_q <= wr_tag;
        p_q <= wr_ppn;
      end
    end

    assign valid_vec[i] = v_q;
    assign dirty_vec[i] = d_q;
    assign ppn_arr[i]   = p_q;
    assign hit_vec[i]   = v_q && (t_q == lk_tag);
  end

  always_comb begin
    lk_ppn   = '0;
    lk_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_ppn   = lk_ppn | ppn_arr[i];
        lk_dirty = lk_dirty | dirty_vec[i];
      end
    end
  end

  assign lk_hit = |hit_vec;

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0));

endmodule

// File: rtl/tlb_walk.sv
module tlb_walk #(
  parameter int CTX_W  = 4,
  parameter int VPN_W  = 22,
  parameter int PPN_W  = 14,
  parameter int ADDR_W = 32,
  localparam int PTE_W = PPN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VPN_W-1:0]  start_vpn,
  input  logic [CTX_W-1:0]  start_ctx,
  input  logic [ADDR_W-1:0] base,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              fill_done,
  output logic              fill_resident,
  output logic              fill_dirty,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic [CTX_W-1:0]  fill_ctx,
  output logic [VPN_W-1:0]  fill_vpn
);
  import ctx_tlb_pkg::*;

  function automatic logic [ADDR_W-1:0] entry_addr(logic [ADDR_W-1:0] b,
                                                   logic [VPN_W-1:0]  v);
    return b + ADDR_W'(v);
  endfunction

  walk_state_e      state_q;
  logic             req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CTX_W-1:0] ctx_q;
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      req_q   <= 1'b0;
      addr_q  <= '0;
      ctx_q   <= '0;
      vpn_q   <= '0;
    end else begin
      req_q <= 1'b0;
      case (state_q)
        WALK_IDLE: if (start) begin
          state_q <= WALK_WAIT;
          req_q   <= 1'b1;
          addr_q  <= entry_addr(base, start_vpn);
          ctx_q   <= start_ctx;
          vpn_q   <= start_vpn;
        end
        WALK_WAIT: if (mem_rsp_valid) state_q <= WALK_IDLE;
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign busy          = (state_q == WALK_WAIT);
  assign mem_req_valid = req_q;
  assign mem_req_addr  = addr_q;
  assign fill_done     = busy && mem_rsp_valid;
  assign fill_resident = mem_rsp_data[PTE_W-1];
  assign fill_dirty    = mem_rsp_data[PTE_W-2];
  assign fill_ppn      = mem_rsp_data[PPN_W-1:0];
  assign fill_ctx      = ctx_q;
  assign fill_vpn      = vpn_q;

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R3
  req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $past(start));

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int CTX_W   = 4,
  parameter int VPN_W   = 22,
  parameter int PPN_W   = 14,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 4,
  localparam int PTE_W  = PPN_W + 2,
  localparam int TAG_W  = CTX_W + VPN_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_we,
  input  logic [CTX_W-1:0]  ctx_wdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              inv_all,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              rsp_dirty,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);

  logic [CTX_W-1:0]  ctx_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q  <= '0;
      base_q <= '0;
    end else begin
      if (ctx_we)  ctx_q  <= ctx_wdata;
      if (base_we) base_q <= base_wdata;
    end
  end

  // named internal events
  logic             accept, hit_now, miss_now, install, walk_busy;
  logic             cam_hit, cam_dirty;
  logic [PPN_W-1:0] cam_ppn;
  logic [IDX_W-1:0] victim;
  logic             fill_done, fill_res, fill_dirty;
  logic [PPN_W-1:0] fill_ppn;
  logic [CTX_W-1:0] fill_ctx;
  logic [VPN_W-1:0] fill_vpn;

  assign lk_ready = !walk_busy;
  assign accept   = lk_valid && lk_ready;
  assign hit_now  = accept && cam_hit;
  assign miss_now = accept && !cam_hit;
  assign install  = fill_done && fill_res && !inv_all;

  tlb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_all  (inv_all),
    .lk_tag   ({ctx_q, lk_vpn}),
    .lk_hit   (cam_hit),
    .lk_ppn   (cam_ppn),
    .lk_dirty (cam_dirty),
    .wr_en    (install),
    .wr_idx   (victim),
    .wr_tag   ({fill_ctx, fill_vpn}),
    .wr_ppn   (fill_ppn),
    .wr_dirty (fill_dirty)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (install),
    .ptr     (victim)
  );

  tlb_walk #(.CTX_W(CTX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .ADDR_W(ADDR_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (miss_now),
    .start_vpn     (lk_vpn),
    .start_ctx     (ctx_q),
    .base          (base_q),
    .busy          (walk_busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .fill_done     (fill_done),
    .fill_resident (fill_res),
    .fill_dirty    (fill_dirty),
    .fill_ppn      (fill_ppn),
    .fill_ctx      (fill_ctx),
    .fill_vpn      (fill_vpn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= hit_now || fill_done;
      if (hit_now) begin
        rsp_hit   <= 1'b1;
        rsp_fault <= 1'b0;
        rsp_dirty <= cam_dirty;
        rsp_ppn   <= cam_ppn;
      end else if (fill_done) begin
        rsp_hit   <= 1'b0;
        rsp_fault <= !fill_res;
        rsp_dirty <= fill_res && fill_dirty;
        rsp_ppn   <= fill_res ? fill_ppn : '0;
      end
    end
  end

  // R4
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !lk_ready);

  // R2
  hit_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(lk_valid && lk_ready));

  // R6
  fault_no_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_ppn == '0 && !rsp_dirty && !rsp_hit));

  // R4
  walk_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_ready && mem_rsp_valid) |=> (rsp_valid && !rsp_hit && lk_ready));

endmodule

// File: tb/ctx_tlb_bench.sv
`timescale 1ns/1ps
module ctx_tlb_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_we = 1'b0;
  logic [3:0]  ctx_wdata = '0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        inv_all = 1'b0;
  logic        lk_valid = 1'b0;
  logic [21:0] lk_vpn = '0;
  logic        lk_ready;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_dirty;
  logic [13:0] rsp_ppn;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  ctx_tlb u_ctx_tlb (
    .clk(clk), .rst_n(rst_n),
    .ctx_we(ctx_we), .ctx_wdata(ctx_wdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .inv_all(inv_all),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_dirty(rsp_dirty), .rsp_ppn(rsp_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit          m_v   [4];
  logic [3:0]  m_ctx [4];
  logic [21:0] m_vpn [4];
  bit          m_d   [4];
  logic [13:0] m_ppn [4];
  int          m_ptr = 0;
  logic [3:0]  cur_ctx = '0;
  logic [31:0] cur_base = '0;

  // page table contents: resident unless address divisible by 5
  function automatic logic [15:0] table_word(logic [31:0] a);
    logic       res = (a % 5) != 0;
    logic [13:0] pg = 14'(a * 37 + 5);
    return {res, a[1], pg};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_ctx(logic [3:0] c);
    @(negedge clk); ctx_we = 1; ctx_wdata = c;
    @(negedge clk); ctx_we = 0;
    cur_ctx = c;
  endtask

  task automatic set_base(logic [31:0] b);
    @(negedge clk); base_we = 1; base_wdata = b;
    @(negedge clk); base_we = 0;
    cur_base = b;
  endtask

  task automatic flush_all();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    for (int i = 0; i < 4; i++) m_v[i] = 0;
  endtask

  task automatic lookup(logic [21:0] vpn, bit collide, string tag);
    int hit_idx = -1;
    logic [15:0] w;
    for (int i = 0; i < 4; i++)
      if (m_v[i] && m_ctx[i] == cur_ctx && m_vpn[i] == vpn) hit_idx = i;
    @(negedge clk); lk_valid = 1; lk_vpn = vpn;
    @(negedge clk); lk_valid = 0;
    if (hit_idx >= 0) begin
      chk(rsp_valid && rsp_hit, tag, "hit response", {rsp_valid, rsp_hit}, 2'b11);
      chk(rsp_ppn == m_ppn[hit_idx], tag, "hit page", rsp_ppn, m_ppn[hit_idx]);
      chk(rsp_dirty == m_d[hit_idx], tag, "hit dirty", rsp_dirty, m_d[hit_idx]);
      chk(!mem_req_valid, tag, "no read on hit", mem_req_valid, 0);
    end else begin
      chk(mem_req_valid, tag, "read issued on miss", mem_req_valid, 1);
      chk(mem_req_addr == cur_base + 32'(vpn), tag, "read address",
          mem_req_addr, cur_base + 32'(vpn));
      chk(!lk_ready && !rsp_valid, tag, "ready low in walk",
          {lk_ready, rsp_valid}, 0);
    end
    if (mem_req_valid) begin
      w = table_word(cur_base + 32'(vpn));
      repeat ($urandom % 4) begin
        @(negedge clk);
        chk(!lk_ready, "R4", "ready held low", lk_ready, 0);
      end
      mem_rsp_valid = 1; mem_rsp_data = w; inv_all = collide;
      @(negedge clk);
      mem_rsp_valid = 0; inv_all = 0;
      chk(rsp_valid && !rsp_hit && lk_ready, tag, "walk response",
          {rsp_valid, rsp_hit, lk_ready}, 3'b101);
      chk(rsp_fault == !w[15], tag, "fault flag", rsp_fault, !w[15]);
      chk(rsp_ppn == (w[15] ? w[13:0] : 14'd0), tag, "walk page",
          rsp_ppn, w[15] ? w[13:0] : 14'd0);
      chk(rsp_dirty == (w[15] && w[14]), tag, "walk dirty", rsp_dirty, w[15] && w[14]);
      if (collide) for (int i = 0; i < 4; i++) m_v[i] = 0;
      else if (w[15] && hit_idx < 0) begin
        m_v[m_ptr] = 1; m_ctx[m_ptr] = cur_ctx; m_vpn[m_ptr] = vpn;
        m_d[m_ptr] = w[14]; m_ppn[m_ptr] = w[13:0];
        m_ptr = (m_ptr + 1) % 4;
      end
    end else if (hit_idx < 0) begin
      @(negedge clk);
    end
  endtask

  // expect-hit/miss helper for directed checks
  task automatic expect_kind(logic [21:0] vpn, bit want_hit, string tag);
    @(negedge clk); lk_valid = 1; lk_vpn = vpn;
    @(negedge clk); lk_valid = 0;
    chk((rsp_valid && rsp_hit) == want_hit, tag, "hit expectation",
        rsp_valid && rsp_hit, want_hit);
    if (mem_req_valid) begin
      mem_rsp_valid = 1; mem_rsp_data = table_word(cur_base + 32'(vpn));
      @(negedge clk); mem_rsp_valid = 0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd7));
    for (int i = 0; i < 4; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lk_ready && !rsp_valid && !mem_req_valid, "R1", "reset outputs",
        {lk_ready, rsp_valid, mem_req_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    set_base(32'h1000);
    set_ctx(4'd1);
    // R1 first lookup misses; R3 R4 R5 walk; R2 hit
    lookup(22'd3, 0, "R1");
    lookup(22'd3, 0, "R2");
    lookup(22'd6, 0, "R5");
    expect_kind(22'd6, 1, "R5");
    // R6 fault (0x1004 divisible by 5), not cached
    lookup(22'd4, 0, "R6");
    expect_kind(22'd4, 0, "R6");
    // R7 contexts
    set_ctx(4'd2);
    expect_kind(22'd3, 0, "R7");
    set_ctx(4'd1);
    for (int i = 0; i < 4; i++) m_v[i] = 0;
    // R8 round robin after flush; model checks eviction order
    flush_all();
    expect_kind(22'd3, 0, "R9");
    flush_all();
    lookup(22'd10, 0, "R8");
    lookup(22'd11, 0, "R8");
    lookup(22'd4,  0, "R8");  // fault must not consume a slot
    lookup(22'd12, 0, "R8");
    lookup(22'd13, 0, "R8");
    lookup(22'd11, 0, "R8");
    lookup(22'd15, 0, "R8");  // evicts page 10
    lookup(22'd12, 0, "R8");
    expect_kind(22'd10, 0, "R8");
    flush_all();
    // R9 invalidate together with fill
    lookup(22'd20, 1, "R9");
    expect_kind(22'd20, 0, "R9");
    flush_all();
    // R10 base write changes next walk address, keeps cached slots
    lookup(22'd1, 0, "R10");
    set_base(32'h2000);
    lookup(22'd1, 0, "R10");
    lookup(22'd2, 0, "R10");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 16;
      if (r == 0)      set_ctx(4'($urandom % 3));
      else if (r == 1) flush_all();
      else if (r == 2) set_base(($urandom % 2) ? 32'h1000 : 32'h2000);
      else             lookup(22'($urandom % 8), r == 3, "R9");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule